// File: doc/BRIEF.md
# Boundary-Scan I/O Cell Chain

This block sits between the core logic and the pad buffers of a row of user I/O pins and gives each pin one boundary-scan cell. A cell holds three capture flops and three update flops. One pair covers the pin's output value, one covers its active-low output enable and one covers the value read back from the pin. The capture flops of all cells are linked into a single serial path from `scan_in` to `scan_out`. A test access controller outside the block supplies the shift, capture and update strobes, the test-mode select and the high-impedance override.

The block has two modes. In normal mode the pin side follows the core, so a snapshot can be captured and shifted out without disturbing normal operation. In test mode the pin output and pin enable come from the update flops, so patterns that were shifted in and then committed drive the board. The high-impedance override turns every pin driver off in either mode. The scan interface is a plain bit-serial path paced by the strobes. It has no valid/ready handshake and no back-pressure: one bit moves on every rising `tck` edge that has `shift_en` high.

Top module: `bsc_chain`

## Requirements
- R1: The chain holds 3 × NUM_CELLS capture bits. Positions are counted from `scan_in`. Cell k occupies positions 3k (pin input), 3k+1 (output enable, active low) and 3k+2 (output data), so cell 0 is nearest `scan_in`. `scan_out` always shows the bit at the last position.
- R2: With `test_mode` = 0 and `force_hiz` = 0, `pin_out` equals `core_out` and `pin_oe_n` equals `core_oe_n`. `core_in` equals `pin_in` in every mode.
- R3: On a rising `tck` edge with `capture_en` = 1 and `shift_en` = 0, every cell loads `core_out`, `core_oe_n` and `pin_in` into its capture flops.
- R4: On a rising `tck` edge with `shift_en` = 1, the whole chain moves one position toward `scan_out` and `scan_in` enters position 0. Shift takes priority over capture.
- R5: On a falling `tck` edge with `update_en` = 1, all capture bits are copied in parallel into the update bits of the same positions. On any other falling edge the update bits hold.
- R6: With `test_mode` = 1 and `force_hiz` = 0, each pin's `pin_out` is its update output bit and `pin_oe_n` is its update enable bit. A 0 in the enable bit drives the pin.
- R7: With `force_hiz` = 1, every `pin_oe_n` bit is 1 whatever the mode and update contents. `pin_out` is unaffected.
- R8: While `rst_n` is low, the capture bits and update output bits are 0 and the update enable bits are 1. After reset, therefore, `scan_out` is 0 and test mode leaves every pin undriven.
- R9: On a rising `tck` edge with neither `shift_en` nor `capture_en`, the capture bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; capture and shift act on its rising edge, update on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_in | input | 1 | Serial data entering chain position 0 |
| scan_out | output | 1 | Serial data from the last chain position |
| shift_en | input | 1 | Shift strobe |
| capture_en | input | 1 | Capture strobe |
| update_en | input | 1 | Update strobe |
| test_mode | input | 1 | 1 selects update flops as pin source, 0 selects core |
| force_hiz | input | 1 | 1 forces every pin enable inactive |
| core_out | input | NUM_CELLS | Output data from the core, one bit per pin |
| core_oe_n | input | NUM_CELLS | Active-low output enable from the core |
| core_in | output | NUM_CELLS | Pin input value returned to the core |
| pin_out | output | NUM_CELLS | Data to the pad output buffers |
| pin_oe_n | output | NUM_CELLS | Active-low enable to the pad output buffers |
| pin_in | input | NUM_CELLS | Value read from the pads |

## Verification
A capture flop that loads the wrong source or sits in the wrong position does not show on the pins. It shows only on `scan_out`, and only after as many shifts as lie between that position and the end of the chain, which can be up to 3 × NUM_CELLS edges later. A stale or miscopied update flop is invisible in normal mode. In test mode it shows on `pin_out` or `pin_oe_n` right after the falling edge that should have committed it. A mode or override mux fault shows at once and combinationally. The bench therefore keeps a bit-accurate model of both flop banks and compares `scan_out` and every pin on every cycle.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int CELL_BITS = 3;
  localparam int FLD_IN    = 0;
  localparam int FLD_OE    = 1;
  localparam int FLD_OUT   = 2;
  typedef logic [CELL_BITS-1:0] cell_bits_t;
  // update bank comes out of reset with drivers off
  localparam cell_bits_t UPD_RESET = cell_bits_t'(1 << FLD_OE);
endpackage

// File: rtl/bsc_cell.sv
module bsc_cell
  import bsc_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       shift_en,
  input  logic       capture_en,
  input  logic       update_en,
  input  logic       ser_in,
  input  cell_bits_t par_in,
  output cell_bits_t cap_q,
  output cell_bits_t upd_q
);
  // capture bank: shift wins over parallel load
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (shift_en) begin
      cap_q <= {cap_q[CELL_BITS-2:0], ser_in};
    end else if (capture_en) begin
      cap_q <= par_in;
    end
  end

  // update bank commits on the falling edge
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= UPD_RESET;
    end else if (update_en) begin
      upd_q <= cap_q;
    end
  end
endmodule

// File: rtl/bsc_pinmux.sv
module bsc_pinmux
  import bsc_pkg::*;
#(
  parameter int NUM_CELLS = 8,
  localparam int CHAIN_LEN = NUM_CELLS * CELL_BITS
) (
  input  logic                 test_mode,
  input  logic                 force_hiz,
  input  logic [NUM_CELLS-1:0] core_out,
  input  logic [NUM_CELLS-1:0] core_oe_n,
  input  logic [CHAIN_LEN-1:0] upd_q,
  input  logic [NUM_CELLS-1:0] pin_in,
  output logic [NUM_CELLS-1:0] pin_out,
  output logic [NUM_CELLS-1:0] pin_oe_n,
  output logic [NUM_CELLS-1:0] core_in
);
  for (genvar k = 0; k < NUM_CELLS; k++) begin : g_pin
    localparam int BASE = k * CELL_BITS;
    logic sel_oe_n;
    always_comb begin
      sel_oe_n   = test_mode ? upd_q[BASE + FLD_OE] : core_oe_n[k];
      pin_oe_n[k] = force_hiz | sel_oe_n;
      pin_out[k]  = test_mode ? upd_q[BASE + FLD_OUT] : core_out[k];
      core_in[k]  = pin_in[k];
    end
  end
endmodule

// File: rtl/bsc_chain.sv
module bsc_chain
  import bsc_pkg::*;
#(
  parameter int NUM_CELLS = 8
) (
  input  logic                 tck,
  input  logic                 rst_n,
  input  logic                 scan_in,
  output logic                 scan_out,
  input  logic                 shift_en,
  input  logic                 capture_en,
  input  logic                 update_en,
  input  logic                 test_mode,
  input  logic                 force_hiz,
  input  logic [NUM_CELLS-1:0] core_out,
  input  logic [NUM_CELLS-1:0] core_oe_n,
  output logic [NUM_CELLS-1:0] core_in,
  output logic [NUM_CELLS-1:0] pin_out,
  output logic [NUM_CELLS-1:0] pin_oe_n,
  input  logic [NUM_CELLS-1:0] pin_in
);
  localparam int CHAIN_LEN = NUM_CELLS * CELL_BITS;

  logic [CHAIN_LEN-1:0] cap_q;
  logic [CHAIN_LEN-1:0] upd_q;

  for (genvar k = 0; k < NUM_CELLS; k++) begin : g_cell
    localparam int BASE = k * CELL_BITS;
    logic       cell_sin;
    cell_bits_t cell_par;

    if (k == 0) begin : g_head
      assign cell_sin = scan_in;
    end else begin : g_link
      assign cell_sin = cap_q[BASE-1];
    end

    always_comb begin
      cell_par          = '0;
      cell_par[FLD_IN]  = pin_in[k];
      cell_par[FLD_OE]  = core_oe_n[k];
      cell_par[FLD_OUT] = core_out[k];
    end

    bsc_cell u_cell (
      .tck        (tck),
      .rst_n      (rst_n),
      .shift_en   (shift_en),
      .capture_en (capture_en),
      .update_en  (update_en),
      .ser_in     (cell_sin),
      .par_in     (cell_par),
      .cap_q      (cap_q[BASE +: CELL_BITS]),
      .upd_q      (upd_q[BASE +: CELL_BITS])
    );
  end

  assign scan_out = cap_q[CHAIN_LEN-1];

  bsc_pinmux #(.NUM_CELLS(NUM_CELLS)) u_pinmux (
    .test_mode (test_mode),
    .force_hiz (force_hiz),
    .core_out  (core_out),
    .core_oe_n (core_oe_n),
    .upd_q     (upd_q),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe_n  (pin_oe_n),
    .core_in   (core_in)
  );
endmodule

// File: rtl/bsc_chain_chk.sv
module bsc_chain_chk
  import bsc_pkg::*;
#(
  parameter int NUM_CELLS = 8,
  localparam int CHAIN_LEN = NUM_CELLS * CELL_BITS
) (
  input logic                 tck,
  input logic                 rst_n,
  input logic                 scan_in,
  input logic                 shift_en,
  input logic                 capture_en,
  input logic                 update_en,
  input logic                 test_mode,
  input logic                 force_hiz,
  input logic [NUM_CELLS-1:0] core_out,
  input logic [NUM_CELLS-1:0] core_oe_n,
  input logic [NUM_CELLS-1:0] pin_in,
  input logic [NUM_CELLS-1:0] core_in,
  input logic [NUM_CELLS-1:0] pin_out,
  input logic [NUM_CELLS-1:0] pin_oe_n,
  input logic [CHAIN_LEN-1:0] cap_q,
  input logic [CHAIN_LEN-1:0] upd_q
);
  function automatic logic [NUM_CELLS-1:0] field(input logic [CHAIN_LEN-1:0] v, input int f);
    logic [NUM_CELLS-1:0] r;
    for (int k = 0; k < NUM_CELLS; k++) r[k] = v[k*CELL_BITS + f];
    return r;
  endfunction

  function automatic logic [CHAIN_LEN-1:0] snap(input logic [NUM_CELLS-1:0] o,
                                                 input logic [NUM_CELLS-1:0] e,
                                                 input logic [NUM_CELLS-1:0] i);
    logic [CHAIN_LEN-1:0] r;
    for (int k = 0; k < NUM_CELLS; k++) begin
      r[k*CELL_BITS + FLD_IN]  = i[k];
      r[k*CELL_BITS + FLD_OE]  = e[k];
      r[k*CELL_BITS + FLD_OUT] = o[k];
    end
    return r;
  endfunction

  a_r2_normal_pass: assert property (@(posedge tck) disable iff (!rst_n)
    (!test_mode && !force_hiz) |-> (pin_out == core_out && pin_oe_n == core_oe_n && core_in == pin_in));

  a_r3_capture_load: assert property (@(posedge tck) disable iff (!rst_n)
    (capture_en && !shift_en) |=> cap_q == $past(snap(core_out, core_oe_n, pin_in)));

  a_r4_shift_step: assert property (@(posedge tck) disable iff (!rst_n)
    shift_en |=> cap_q == {$past(cap_q[CHAIN_LEN-2:0]), $past(scan_in)});

  a_r9_idle_hold: assert property (@(posedge tck) disable iff (!rst_n)
    (!shift_en && !capture_en) |=> $stable(cap_q));

  a_r5_update_copy: assert property (@(negedge tck) disable iff (!rst_n)
    update_en |=> upd_q == $past(cap_q));

  a_r5_update_hold: assert property (@(negedge tck) disable iff (!rst_n)
    !update_en |=> $stable(upd_q));

  a_r6_test_drive: assert property (@(posedge tck) disable iff (!rst_n)
    (test_mode && !force_hiz) |-> (pin_out == field(upd_q, FLD_OUT) && pin_oe_n == field(upd_q, FLD_OE)));

  a_r7_hiz_off: assert property (@(posedge tck) disable iff (!rst_n)
    force_hiz |-> (&pin_oe_n));
endmodule

bind bsc_chain bsc_chain_chk #(.NUM_CELLS(NUM_CELLS)) u_chk (
  .tck        (tck),
  .rst_n      (rst_n),
  .scan_in    (scan_in),
  .shift_en   (shift_en),
  .capture_en (capture_en),
  .update_en  (update_en),
  .test_mode  (test_mode),
  .force_hiz  (force_hiz),
  .core_out   (core_out),
  .core_oe_n  (core_oe_n),
  .pin_in     (pin_in),
  .core_in    (core_in),
  .pin_out    (pin_out),
  .pin_oe_n   (pin_oe_n),
  .cap_q      (cap_q),
  .upd_q      (upd_q)
);

// File: tb/bsc_chain_bench.sv
module bsc_chain_bench;
  localparam int N = 8;
  localparam int L = 3 * N;

  logic         tck = 1'b0;
  logic         rst_n = 1'b0;
  logic         scan_in = 1'b0;
  logic         scan_out;
  logic         shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0;
  logic         test_mode = 1'b0, force_hiz = 1'b0;
  logic [N-1:0] core_out = '0, core_oe_n = '1, pin_in = '0;
  logic [N-1:0] core_in, pin_out, pin_oe_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [L-1:0] m_cap;
  logic [L-1:0] m_upd;

  always #2 tck = ~tck;

  bsc_chain #(.NUM_CELLS(N)) u_bsc_chain (
    .tck(tck), .rst_n(rst_n), .scan_in(scan_in), .scan_out(scan_out),
    .shift_en(shift_en), .capture_en(capture_en), .update_en(update_en),
    .test_mode(test_mode), .force_hiz(force_hiz),
    .core_out(core_out), .core_oe_n(core_oe_n), .core_in(core_in),
    .pin_out(pin_out), .pin_oe_n(pin_oe_n), .pin_in(pin_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected capture snapshot: cell k -> in at 3k, oe_n at 3k+1, out at 3k+2
  function automatic logic [L-1:0] exp_snap();
    logic [L-1:0] r;
    for (int k = 0; k < N; k++) begin
      r[3*k]   = pin_in[k];
      r[3*k+1] = core_oe_n[k];
      r[3*k+2] = core_out[k];
    end
    return r;
  endfunction

  function automatic logic [N-1:0] exp_out();
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) r[k] = test_mode ? m_upd[3*k+2] : core_out[k];
    return r;
  endfunction

  function automatic logic [N-1:0] exp_oe();
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) r[k] = force_hiz | (test_mode ? m_upd[3*k+1] : core_oe_n[k]);
    return r;
  endfunction

  task automatic verify();
    chk(scan_out == m_cap[L-1], "R4 scan_out", 64'(scan_out), 64'(m_cap[L-1]));
    chk(pin_out == exp_out(), test_mode ? "R6 pin_out" : "R2 pin_out", 64'(pin_out), 64'(exp_out()));
    chk(pin_oe_n == exp_oe(), force_hiz ? "R7 pin_oe_n" : (test_mode ? "R6 pin_oe_n" : "R2 pin_oe_n"),
        64'(pin_oe_n), 64'(exp_oe()));
    chk(core_in == pin_in, "R2 core_in", 64'(core_in), 64'(pin_in));
  endtask

  // one tck period starting just after a rising edge
  task automatic cyc(input logic sh, input logic cp, input logic up, input logic si);
    shift_en = sh; capture_en = cp; update_en = up; scan_in = si;
    @(negedge tck);
    if (up) m_upd = m_cap;
    @(posedge tck);
    if (sh) m_cap = {m_cap[L-2:0], si};
    else if (cp) m_cap = exp_snap();
    #1;
    verify();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int unsigned seed = 32'd20240611;
    logic [L-1:0] pat;
    void'($urandom(seed));
    m_cap = '0;
    m_upd = '0;
    for (int k = 0; k < N; k++) m_upd[3*k+1] = 1'b1;

    // R8: reset state, viewed through test mode
    test_mode = 1'b1;
    #9; rst_n = 1'b1;
    @(posedge tck); #1;
    chk(scan_out == 1'b0, "R8 scan_out", 64'(scan_out), 64'd0);
    chk(pin_oe_n == '1, "R8 pin_oe_n", 64'(pin_oe_n), 64'({N{1'b1}}));
    chk(pin_out == '0, "R8 pin_out", 64'(pin_out), 64'd0);
    test_mode = 1'b0;

    // R3/R1: capture known values and check bit order at scan_out
    core_out = 8'hA5; core_oe_n = 8'h3C; pin_in = 8'h96;
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    chk(scan_out == core_out[N-1], "R1 last pos is out of last cell", 64'(scan_out), 64'(core_out[N-1]));
    cyc(1'b1, 1'b0, 1'b0, 1'b1);
    chk(scan_out == core_oe_n[N-1], "R1 then oe_n of last cell", 64'(scan_out), 64'(core_oe_n[N-1]));
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    chk(scan_out == pin_in[N-1], "R1 then in of last cell", 64'(scan_out), 64'(pin_in[N-1]));

    // R9: idle edges hold (observed at scan_out after more shifting)
    pat = m_cap;
    for (int i = 0; i < 5; i++) begin
      core_out = 8'(~core_out);
      cyc(1'b0, 1'b0, 1'b0, 1'b1);
    end
    chk(m_cap == pat, "R9 model hold", 64'(m_cap), 64'(pat));
    for (int i = 0; i < L - 3; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0);

    // R4: shift wins over simultaneous capture, pattern crosses 3N positions
    pat = L'({$urandom, $urandom});
    for (int i = L - 1; i >= 0; i--) cyc(1'b1, 1'b1, 1'b0, pat[i]);
    for (int i = L - 1; i >= 0; i--) begin
      chk(scan_out == pat[i], "R4 pattern emerges after 3N shifts", 64'(scan_out), 64'(pat[i]));
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
    end

    // R5/R6: preload, commit, drive pins in test mode
    pat = L'({$urandom, $urandom});
    for (int i = L - 1; i >= 0; i--) cyc(1'b1, 1'b0, 1'b0, pat[i]);
    test_mode = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    chk(pin_oe_n == '1, "R5 no commit without strobe", 64'(pin_oe_n), 64'({N{1'b1}}));
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < N; k++) begin
      chk(pin_out[k] == pat[3*k+2], "R6 pin_out from update", 64'(pin_out[k]), 64'(pat[3*k+2]));
      chk(pin_oe_n[k] == pat[3*k+1], "R6 pin_oe_n from update", 64'(pin_oe_n[k]), 64'(pat[3*k+1]));
    end
    force_hiz = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    chk(pin_oe_n == '1, "R7 override", 64'(pin_oe_n), 64'({N{1'b1}}));
    force_hiz = 1'b0;

    // random mix against the model
    for (int i = 0; i < 2000; i++) begin
      core_out  = N'($urandom);
      core_oe_n = N'($urandom);
      pin_in    = N'($urandom);
      test_mode = 1'($urandom);
      force_hiz = ($urandom % 8) == 0;
      cyc(1'($urandom), 1'($urandom), ($urandom % 4) == 0, 1'($urandom));
    end

    done = 1;
    summary();
  end
endmodule